// File: doc/BRIEF.md
# Port Change Interrupt Controller

This block watches four upper port pins for a change of level and combines that change indication with an edge-triggered external interrupt pin and a peripheral event into one interrupt request for the processor core. Each pin level is first passed through a synchronizer. The synchronized level is then compared with a reference value. The reference is loaded whenever the core reads the port. Any difference on any monitored pin raises the port-change flag. Detection is armed only while every monitored pin is configured as an input.

All three flags are sticky and are cleared by software writing a 0 to the flag's bit. A set event that arrives in the same cycle as the clear takes priority, so no event is lost. The request to the core is gated first by a per-source enable and then by a global enable. While the request is active, the block drives the fixed interrupt vector address for the program counter.

Top module: `pchg_irq_ctrl`

## Requirements
- R1: After reset, `flags_o` is 000, `irq_o` is 0 and `vec_o` is 0.
- R2: A level change on any of the monitored pins, relative to the reference value, sets flag bit 0 (port change). The flag becomes visible after the third rising clock edge following the pin change: two edges are spent in the synchronizer and one in the flag register.
- R3: While any bit of `dir_i` is 0 (output), the monitored pins never set flag bit 0. A `dir_i` value of 1 means the pin is an input.
- R4: A pulse on `port_rd_i` loads the synchronized pin levels into the reference value. This removes the mismatch, but it does not clear flag bit 0.
- R5: A cycle with `clr_we_i`=1 clears every flag whose bit in `clr_data_i` is 0. Flags whose bit is 1 keep their value. Outside such a clear, a flag that is set stays set.
- R6: If a flag's set condition and its clear arrive in the same cycle, the flag ends up set.
- R7: With `ext_rise_i`=1, a rising edge on `ext_pin_i` sets flag bit 1 and a falling edge does not. With `ext_rise_i`=0, a falling edge sets it and a rising edge does not. The latency is the same three edges as in R2.
- R8: A one-cycle pulse on `per_evt_i` sets flag bit 2 at the next rising edge.
- R9: `irq_o` is 1 exactly when `gie_i` is 1 and at least one flag is set whose enable bit is also set. `en_i` bit k enables flag bit k.
- R10: `vec_o` equals 0x004 while `irq_o` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | Levels of the monitored upper port pins |
| dir_i | input | 4 | Direction bits of those pins, 1 = input |
| ext_pin_i | input | 1 | External interrupt pin |
| ext_rise_i | input | 1 | 1 = rising edge, 0 = falling edge on ext_pin_i |
| per_evt_i | input | 1 | Peripheral event pulse |
| en_i | input | 3 | Per-source enables (bit0 change, bit1 external, bit2 peripheral) |
| gie_i | input | 1 | Global interrupt enable |
| port_rd_i | input | 1 | Port read strobe, reloads the reference value |
| clr_we_i | input | 1 | Flag clear write strobe |
| clr_data_i | input | 3 | Clear data, a 0 bit clears the matching flag |
| flags_o | output | 3 | Sticky flags (bit0 change, bit1 external, bit2 peripheral) |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 13 | Interrupt vector address, 0x004 while irq_o is high |

## Verification
A corrupted reference register appears at the ports as a change flag that sets with no pin movement, or that sets again right after a read and clear. This is visible three cycles after the read at the latest. A synchronizer with the wrong depth shifts the latency of flag bits 0 and 1 by one edge. The bench catches this because it samples both the cycle before and the cycle of the expected set. A wrong gating or flag state shows up on `irq_o` and `vec_o` in the same cycle as the flag change.

// File: rtl/pchg_pkg.sv
package pchg_pkg;
   localparam int unsigned NUM_SRC   = 3;
   localparam int unsigned SRC_CHG   = 0;
   localparam int unsigned SRC_EXT   = 1;
   localparam int unsigned SRC_PER   = 2;
   localparam int unsigned PC_W      = 13;
   localparam logic [PC_W-1:0] IRQ_VEC = 13'h004;
endpackage

// File: rtl/pchg_sync.sv
module pchg_sync #(
   parameter int unsigned W      = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pchg_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("pchg_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pchg_change_det.sv
module pchg_change_det #(
   parameter int unsigned NUM_PINS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] lvl_i,
   input  logic [NUM_PINS-1:0] dir_i,
   input  logic                load_i,
   output logic                chg_o
);
   if (NUM_PINS < 1) begin : g_bad_pins
      $error("pchg_change_det: NUM_PINS must be at least 1");
   end

   logic [NUM_PINS-1:0] ref_q;
   logic [NUM_PINS-1:0] diff;
   logic                armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ref_q <= '0;
      else if (load_i) ref_q <= lvl_i;
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign diff[p] = lvl_i[p] ^ ref_q[p];
   end

   assign armed = &dir_i;
   assign chg_o = armed & (|diff);
endmodule

// File: rtl/pchg_edge_det.sv
module pchg_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic rise_sel_i,
   output logic evt_o
);
   logic prev_q;
   logic rise;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   assign rise  = lvl_i & ~prev_q;
   assign fall  = ~lvl_i & prev_q;
   assign evt_o = rise_sel_i ? rise : fall;
endmodule

// File: rtl/pchg_flag_gate.sv
module pchg_flag_gate #(
   parameter int unsigned       N       = 3,
   parameter int unsigned       VW      = 13,
   parameter logic [VW-1:0]     VEC     = 13'h004
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  set_i,
   input  logic          clr_we_i,
   input  logic [N-1:0]  clr_data_i,
   input  logic [N-1:0]  en_i,
   input  logic          gie_i,
   output logic [N-1:0]  flags_o,
   output logic          irq_o,
   output logic [VW-1:0] vec_o
);
   if (N < 1) begin : g_bad_n
      $error("pchg_flag_gate: N must be at least 1");
   end

   logic [N-1:0] flag_q;
   logic [N-1:0] clr;

   for (genvar k = 0; k < N; k++) begin : g_flag
      assign clr[k] = clr_we_i & ~clr_data_i[k];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q[k] <= 1'b0;
         else        flag_q[k] <= set_i[k] | (flag_q[k] & ~clr[k]);
      end
   end

   assign flags_o = flag_q;
   assign irq_o   = gie_i & (|(flag_q & en_i));
   assign vec_o   = irq_o ? VEC : '0;
endmodule

// File: rtl/pchg_irq_ctrl.sv
module pchg_irq_ctrl
   import pchg_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic [NUM_PINS-1:0] dir_i,
   input  logic                ext_pin_i,
   input  logic                ext_rise_i,
   input  logic                per_evt_i,
   input  logic [NUM_SRC-1:0]  en_i,
   input  logic                gie_i,
   input  logic                port_rd_i,
   input  logic                clr_we_i,
   input  logic [NUM_SRC-1:0]  clr_data_i,
   output logic [NUM_SRC-1:0]  flags_o,
   output logic                irq_o,
   output logic [PC_W-1:0]     vec_o
);
   localparam int unsigned SYNC_W = NUM_PINS + 1;

   logic [SYNC_W-1:0]   raw_lvl;
   logic [SYNC_W-1:0]   sync_lvl;
   logic [NUM_PINS-1:0] pin_sync;
   logic                ext_sync;
   logic                chg_evt;
   logic                ext_evt;
   logic [NUM_SRC-1:0]  set_vec;

   assign raw_lvl  = {ext_pin_i, pin_i};
   assign pin_sync = sync_lvl[NUM_PINS-1:0];
   assign ext_sync = sync_lvl[NUM_PINS];

   pchg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_lvl),
      .q_o   (sync_lvl)
   );

   pchg_change_det #(.NUM_PINS(NUM_PINS)) u_chg (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (pin_sync),
      .dir_i  (dir_i),
      .load_i (port_rd_i),
      .chg_o  (chg_evt)
   );

   pchg_edge_det u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_i      (ext_sync),
      .rise_sel_i (ext_rise_i),
      .evt_o      (ext_evt)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[SRC_CHG] = chg_evt;
      set_vec[SRC_EXT] = ext_evt;
      set_vec[SRC_PER] = per_evt_i;
   end

   pchg_flag_gate #(.N(NUM_SRC), .VW(PC_W), .VEC(IRQ_VEC)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (set_vec),
      .clr_we_i   (clr_we_i),
      .clr_data_i (clr_data_i),
      .en_i       (en_i),
      .gie_i      (gie_i),
      .flags_o    (flags_o),
      .irq_o      (irq_o),
      .vec_o      (vec_o)
   );
endmodule

// File: rtl/pchg_irq_ctrl_chk.sv
module pchg_irq_ctrl_chk
   import pchg_pkg::*;
#(
   parameter int unsigned NUM_PINS = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] dir_i,
   input logic                per_evt_i,
   input logic [NUM_SRC-1:0]  en_i,
   input logic                gie_i,
   input logic                clr_we_i,
   input logic [NUM_SRC-1:0]  clr_data_i,
   input logic [NUM_SRC-1:0]  flags_o,
   input logic                irq_o,
   input logic [PC_W-1:0]     vec_o
);
   AST_GIE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) !gie_i |-> !irq_o); // R9
   AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> |(flags_o & en_i)); // R9
   AST_VEC_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> vec_o == IRQ_VEC); // R10
   AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !irq_o |-> vec_o == '0); // R10
   AST_CHG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[SRC_CHG] && !(clr_we_i && !clr_data_i[SRC_CHG])) |=> flags_o[SRC_CHG]); // R5
   AST_EXT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[SRC_EXT] && !(clr_we_i && !clr_data_i[SRC_EXT])) |=> flags_o[SRC_EXT]); // R5
   AST_PER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[SRC_PER] && !(clr_we_i && !clr_data_i[SRC_PER])) |=> flags_o[SRC_PER]); // R5
   AST_PER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && !clr_data_i[SRC_PER] && !per_evt_i) |=> !flags_o[SRC_PER]); // R5
   AST_PER_SET: assert property (@(posedge clk) disable iff (!rst_n) per_evt_i |=> flags_o[SRC_PER]); // R8
   AST_NO_CHG_WHEN_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags_o[SRC_CHG] && !(&dir_i)) |=> !flags_o[SRC_CHG]); // R3
endmodule

bind pchg_irq_ctrl pchg_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/sim_pchg_irq_ctrl.sv
module sim_pchg_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  pin_i = '0;
   logic [3:0]  dir_i = 4'b1111;
   logic        ext_pin_i = 1'b0;
   logic        ext_rise_i = 1'b1;
   logic        per_evt_i = 1'b0;
   logic [2:0]  en_i = '0;
   logic        gie_i = 1'b0;
   logic        port_rd_i = 1'b0;
   logic        clr_we_i = 1'b0;
   logic [2:0]  clr_data_i = 3'b111;
   logic [2:0]  flags_o;
   logic        irq_o;
   logic [12:0] vec_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   pchg_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .dir_i(dir_i),
      .ext_pin_i(ext_pin_i), .ext_rise_i(ext_rise_i), .per_evt_i(per_evt_i),
      .en_i(en_i), .gie_i(gie_i), .port_rd_i(port_rd_i),
      .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
      .flags_o(flags_o), .irq_o(irq_o), .vec_o(vec_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_all();
      port_rd_i = 1'b1; cyc(1); port_rd_i = 1'b0;
      clr_we_i = 1'b1; clr_data_i = 3'b000; cyc(1);
      clr_we_i = 1'b0; clr_data_i = 3'b111; cyc(1);
   endtask

   task automatic t_reset();
      check("R1 flags", {29'd0, flags_o}, 32'd0);
      check("R1 irq", {31'd0, irq_o}, 32'd0);
      check("R1 vec", {19'd0, vec_o}, 32'd0);
   endtask

   task automatic t_change();
      pin_i = 4'b0100; cyc(2);
      check("R2 not yet after two edges", {31'd0, flags_o[0]}, 32'd0);
      cyc(1);
      check("R2 change flag set", {31'd0, flags_o[0]}, 32'd1);
      clr_we_i = 1'b1; clr_data_i = 3'b110; cyc(1);
      clr_we_i = 1'b0; clr_data_i = 3'b111;
      check("R6 set beats clear", {31'd0, flags_o[0]}, 32'd1);
      port_rd_i = 1'b1; cyc(1); port_rd_i = 1'b0; cyc(3);
      check("R4 flag held after read", {31'd0, flags_o[0]}, 32'd1);
      clr_we_i = 1'b1; clr_data_i = 3'b110; cyc(1);
      clr_we_i = 1'b0; clr_data_i = 3'b111; cyc(4);
      check("R4 no re-set after read and clear", {31'd0, flags_o[0]}, 32'd0);
      pin_i = 4'b1101; cyc(3);
      check("R2 multi-pin change", {31'd0, flags_o[0]}, 32'd1);
      clear_all();
   endtask

   task automatic t_dir();
      dir_i = 4'b1011; pin_i = 4'b0010; cyc(6);
      check("R3 no flag with output pin", {31'd0, flags_o[0]}, 32'd0);
      dir_i = 4'b1111; cyc(2);
      check("R3 flag once all inputs", {31'd0, flags_o[0]}, 32'd1);
      clear_all();
   endtask

   task automatic t_ext();
      ext_rise_i = 1'b1; ext_pin_i = 1'b1; cyc(2);
      check("R7 rise latency", {31'd0, flags_o[1]}, 32'd0);
      cyc(1);
      check("R7 rising edge sets", {31'd0, flags_o[1]}, 32'd1);
      clear_all();
      ext_pin_i = 1'b0; cyc(5);
      check("R7 falling ignored in rise mode", {31'd0, flags_o[1]}, 32'd0);
      ext_rise_i = 1'b0; ext_pin_i = 1'b1; cyc(5);
      check("R7 rising ignored in fall mode", {31'd0, flags_o[1]}, 32'd0);
      ext_pin_i = 1'b0; cyc(3);
      check("R7 falling edge sets", {31'd0, flags_o[1]}, 32'd1);
      clear_all();
      ext_rise_i = 1'b1;
   endtask

   task automatic t_per_clear();
      per_evt_i = 1'b1; cyc(1); per_evt_i = 1'b0;
      check("R8 peripheral flag", {29'd0, flags_o}, 32'b100);
      pin_i = 4'b0000; cyc(3);
      check("R5 two flags set", {29'd0, flags_o}, 32'b101);
      clr_we_i = 1'b1; clr_data_i = 3'b011; cyc(1);
      clr_we_i = 1'b0; clr_data_i = 3'b111;
      check("R5 selective clear", {29'd0, flags_o}, 32'b001);
      clr_data_i = 3'b000; cyc(2); clr_data_i = 3'b111;
      check("R5 no clear without strobe", {29'd0, flags_o}, 32'b001);
      clear_all();
      check("R5 all cleared", {29'd0, flags_o}, 32'd0);
   endtask

   task automatic t_irq();
      per_evt_i = 1'b1; cyc(1); per_evt_i = 1'b0;
      en_i = 3'b100; gie_i = 1'b0; #1;
      check("R9 global off", {31'd0, irq_o}, 32'd0);
      check("R10 vec idle", {19'd0, vec_o}, 32'd0);
      gie_i = 1'b1; #1;
      check("R9 irq on", {31'd0, irq_o}, 32'd1);
      check("R10 vec on irq", {19'd0, vec_o}, 32'h004);
      en_i = 3'b011; #1;
      check("R9 source disabled", {31'd0, irq_o}, 32'd0);
      cyc(1);
      clear_all();
      en_i = 3'b111; #1;
      check("R9 no flags", {31'd0, irq_o}, 32'd0);
      gie_i = 1'b0; en_i = 3'b000;
      cyc(1);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cyc(1);
      t_reset();
      rst_n = 1'b1;
      cyc(2);
      t_change();
      t_dir();
      t_ext();
      t_per_clear();
      t_irq();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule